// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the processor-side register file of a four-channel DMA controller. A host reaches it through a 4-bit port offset and an 8-bit data bus. Each channel has a 16-bit address and a 16-bit word count. Both are loaded one byte per access, and a single byte-pointer flip-flop, shared by all of these registers, picks the low or the high half. Every byte write lands in both the base copy and the current copy. The file also holds the following:

- a per-channel mode register;
- a command byte;
- a mask bit per channel;
- a software request bit per channel;
- terminal-count flags.

Several offsets act only as strobes, and the data written to them has no effect.

A transfer engine takes the decoded configuration from the output ports. It returns one-cycle terminal-count pulses, which the file records as status. Page registers, bus arbitration and transfer sequencing belong to other blocks.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all mask bits are 1 and the command byte is 0. Mode and software request bits are 0, the status byte reads 0x00, and the byte pointer selects the low byte.
- R2: A write to offset 2n targets the address of channel n, and a write to offset 2n+1 targets its count. The first byte goes to bits 7:0 and the second to bits 15:8. Each byte write updates the base copy and the current copy alike.
- R3: All accesses to offsets 0..7 share one byte pointer, and each such read or write toggles it. A read at those offsets returns the byte of the current copy that the pointer selects.
- R4: Any write to offset 0xC returns the byte pointer to the low byte, whatever the data.
- R5: Any write to offset 0xD clears the command byte, the software requests and the terminal-count flags. It also sets all mask bits and returns the pointer to low. Mode, address and count registers keep their values.
- R6: Any write to offset 0xE clears all four mask bits.
- R7: A write to offset 0xA sets the mask of the channel in data bits 1:0 to data bit 2, where 1 masks the channel. A write to offset 0xF loads all masks from data bits 3:0, with bit n for channel n.
- R8: A write to offset 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the software request of the channel in data bits 1:0. A request reaches `req_o` and status only while that channel's mode field is block (10).
- R9: A write to offset 0xB stores data bits 7:2 as the mode of the channel in bits 1:0. That channel's 6-bit slice of `mode_o` then holds, from its top bit down: mode in bits 5:4 (00 demand, 01 single, 10 block, 11 cascade), decrement in bit 3, autoinitialize in bit 2, and type in bits 1:0 (00 verify, 01 write, 10 read).
- R10: A read at offset 8 returns status. Bit 4+n is the effective request of channel n, and bit n is its terminal-count flag, which a pulse on `tc_i[n]` sets.
- R11: A status read clears bits 3:0 on the next edge and leaves bits 7:4 alone. A terminal-count pulse arriving in the same cycle as the read still leaves its flag set.
- R12: A write to offset 8 loads the command byte, and `cmd_o` presents it.
- R13: Reads at offsets 9 to 0xF return 0x00. When write and read are asserted together, the write is taken and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the offset |
| tc_i | input | 4 | Terminal-count pulses from the engine |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel masks, bit n is channel n |
| req_o | output | 4 | Effective software requests |
| mode_o | output | 24 | Mode slices, 6 bits per channel |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| cur_addr_o | output | 64 | Current addresses |
| base_cnt_o | output | 64 | Base counts |
| cur_cnt_o | output | 64 | Current counts |

## Verification
The bench builds the block with its default package sizing: four channels, 16-bit words and 8-bit bytes. At that size every byte lane and every channel select code can be reached by a port write. Sequences of interleaved writes and reads probe the shared pointer between address and count. A status read is placed in the same cycle as a terminal-count pulse to exercise the R11 race, and a master reset is issued while the pointer sits on the high byte and flags are pending.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int CH_N   = 4;
  localparam int CH_W   = $clog2(CH_N);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = 6;

  typedef enum logic [1:0] {
    XF_DEMAND  = 2'b00,
    XF_SINGLE  = 2'b01,
    XF_BLOCK   = 2'b10,
    XF_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [3:0] {
    OFS_STAT_CMD = 4'h8,
    OFS_REQ      = 4'h9,
    OFS_SMASK    = 4'hA,
    OFS_MODE     = 4'hB,
    OFS_PTRCLR   = 4'hC,
    OFS_MRST     = 4'hD,
    OFS_MASKCLR  = 4'hE,
    OFS_MASKALL  = 4'hF
  } ofs_e;

  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] w,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    logic [WORD_W-1:0] r;
    r = w;
    if (hi) r[WORD_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic xfer_mode_e mode_of(input logic [MODE_W-1:0] m);
    return xfer_mode_e'(m[MODE_W-1:MODE_W-2]);
  endfunction
endpackage

// File: rtl/dma_rf_strobe.sv
module dma_rf_strobe
  import dma_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] addr_i,
  output logic       ch_wr_o,
  output logic       ch_acc_o,
  output logic       cmd_wr_o,
  output logic       stat_rd_o,
  output logic       req_wr_o,
  output logic       smask_wr_o,
  output logic       mode_wr_o,
  output logic       ptr_clr_o,
  output logic       mrst_o,
  output logic       mask_clr_o,
  output logic       mask_all_o,
  output logic       ptr_hi_o
);
  logic wr_v, rd_v, ptr_q;

  assign wr_v       = cs_i & wr_i;
  assign rd_v       = cs_i & rd_i & ~wr_i;
  assign ch_wr_o    = wr_v & ~addr_i[3];
  assign ch_acc_o   = (wr_v | rd_v) & ~addr_i[3];
  assign cmd_wr_o   = wr_v & (addr_i == OFS_STAT_CMD);
  assign stat_rd_o  = rd_v & (addr_i == OFS_STAT_CMD);
  assign req_wr_o   = wr_v & (addr_i == OFS_REQ);
  assign smask_wr_o = wr_v & (addr_i == OFS_SMASK);
  assign mode_wr_o  = wr_v & (addr_i == OFS_MODE);
  assign ptr_clr_o  = wr_v & (addr_i == OFS_PTRCLR);
  assign mrst_o     = wr_v & (addr_i == OFS_MRST);
  assign mask_clr_o = wr_v & (addr_i == OFS_MASKCLR);
  assign mask_all_o = wr_v & (addr_i == OFS_MASKALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ptr_q <= 1'b0;
    else if (ptr_clr_o || mrst_o)  ptr_q <= 1'b0;
    else if (ch_acc_o)             ptr_q <= ~ptr_q;
  end
  assign ptr_hi_o = ptr_q;

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_acc_o |=> ptr_hi_o != $past(ptr_hi_o)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_clr_o || mrst_o) |=> !ptr_hi_o); // R4
endmodule

// File: rtl/dma_rf_word.sv
module dma_rf_word
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WORD_W-1:0] base_o,
  output logic [WORD_W-1:0] cur_o
);
  logic [WORD_W-1:0] base_q, cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_en_i) begin
      base_q <= merge_byte(base_q, wdata_i, hi_i);
      cur_q  <= merge_byte(cur_q, wdata_i, hi_i);
    end
  end
  assign base_o = base_q;
  assign cur_o  = cur_q;

  AST_WR_BOTH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> pick_byte(base_o, $past(hi_i)) == $past(wdata_i)
                && pick_byte(cur_o, $past(hi_i)) == $past(wdata_i)); // R2
endmodule

// File: rtl/dma_rf_ctl.sv
module dma_rf_ctl
  import dma_rf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_W-1:0]        wdata_i,
  input  logic                     cmd_wr_i,
  input  logic                     stat_rd_i,
  input  logic                     req_wr_i,
  input  logic                     smask_wr_i,
  input  logic                     mode_wr_i,
  input  logic                     mrst_i,
  input  logic                     mask_clr_i,
  input  logic                     mask_all_i,
  input  logic [CH_N-1:0]          tc_i,
  output logic [BYTE_W-1:0]        cmd_o,
  output logic [CH_N*MODE_W-1:0]   mode_o,
  output logic [CH_N-1:0]          mask_o,
  output logic [CH_N-1:0]          req_o,
  output logic [BYTE_W-1:0]        status_o
);
  logic [CH_W-1:0]   sel;
  logic [BYTE_W-1:0] cmd_q;
  logic [CH_N-1:0]   mask_q, req_q, tc_q;
  logic [MODE_W-1:0] mode_q [CH_N];

  assign sel = wdata_i[CH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q <= '0;
    else if (mrst_i)   cmd_q <= '0;
    else if (cmd_wr_i) cmd_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '1;
    else if (mrst_i)     mask_q <= '1;
    else if (mask_clr_i) mask_q <= '0;
    else if (mask_all_i) mask_q <= wdata_i[CH_N-1:0];
    else if (smask_wr_i) mask_q[sel] <= wdata_i[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_q <= '0;
    else if (mrst_i)   req_q <= '0;
    else if (req_wr_i) req_q[sel] <= wdata_i[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_q <= '0;
    else if (mrst_i) tc_q <= '0;
    else             tc_q <= (stat_rd_i ? '0 : tc_q) | tc_i;
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mode_q[i] <= '0;
      else if (mode_wr_i && sel == CH_W'(i)) mode_q[i] <= wdata_i[BYTE_W-1:BYTE_W-MODE_W];
    end
    assign mode_o[i*MODE_W +: MODE_W] = mode_q[i];
    assign req_o[i] = req_q[i] & (mode_of(mode_q[i]) == XF_BLOCK);

    AST_TC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_i[i] && !mrst_i) |=> status_o[i]); // R10
    AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o[i]) |-> ($past(req_wr_i) || $past(mode_wr_i))); // R8
  end

  assign cmd_o    = cmd_q;
  assign mask_o   = mask_q;
  assign status_o = {req_o, tc_q};

  AST_MRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_i |=> (mask_o == '1 && cmd_o == '0 && req_o == '0 && status_o == '0)); // R5
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr_i |=> mask_o == '0); // R6
  AST_TC_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && tc_i == '0) |=> status_o[CH_N-1:0] == '0); // R11
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [3:0]               addr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rdata_o,
  input  logic [CH_N-1:0]          tc_i,
  output logic [BYTE_W-1:0]        cmd_o,
  output logic [CH_N-1:0]          mask_o,
  output logic [CH_N-1:0]          req_o,
  output logic [CH_N*MODE_W-1:0]   mode_o,
  output logic [CH_N*WORD_W-1:0]   base_addr_o,
  output logic [CH_N*WORD_W-1:0]   cur_addr_o,
  output logic [CH_N*WORD_W-1:0]   base_cnt_o,
  output logic [CH_N*WORD_W-1:0]   cur_cnt_o
);
  localparam int REG_N = 2 * CH_N;

  logic ch_wr, ch_acc, cmd_wr, stat_rd, req_wr, smask_wr, mode_wr;
  logic ptr_clr, mrst, mask_clr, mask_all, ptr_hi;
  logic [BYTE_W-1:0] status;
  logic [WORD_W-1:0] base_w [REG_N];
  logic [WORD_W-1:0] cur_w  [REG_N];

  dma_rf_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .ch_wr_o(ch_wr), .ch_acc_o(ch_acc), .cmd_wr_o(cmd_wr), .stat_rd_o(stat_rd),
    .req_wr_o(req_wr), .smask_wr_o(smask_wr), .mode_wr_o(mode_wr),
    .ptr_clr_o(ptr_clr), .mrst_o(mrst), .mask_clr_o(mask_clr),
    .mask_all_o(mask_all), .ptr_hi_o(ptr_hi)
  );

  for (genvar r = 0; r < REG_N; r++) begin : g_reg
    dma_rf_word u_word (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(ch_wr && addr_i[2:0] == 3'(r)),
      .hi_i(ptr_hi), .wdata_i(wdata_i),
      .base_o(base_w[r]), .cur_o(cur_w[r])
    );
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_out
    assign base_addr_o[i*WORD_W +: WORD_W] = base_w[2*i];
    assign cur_addr_o [i*WORD_W +: WORD_W] = cur_w[2*i];
    assign base_cnt_o [i*WORD_W +: WORD_W] = base_w[2*i+1];
    assign cur_cnt_o  [i*WORD_W +: WORD_W] = cur_w[2*i+1];
  end

  dma_rf_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wdata_i(wdata_i),
    .cmd_wr_i(cmd_wr), .stat_rd_i(stat_rd), .req_wr_i(req_wr),
    .smask_wr_i(smask_wr), .mode_wr_i(mode_wr), .mrst_i(mrst),
    .mask_clr_i(mask_clr), .mask_all_i(mask_all), .tc_i(tc_i),
    .cmd_o(cmd_o), .mode_o(mode_o), .mask_o(mask_o), .req_o(req_o),
    .status_o(status)
  );

  always_comb begin
    if (!addr_i[3])                 rdata_o = pick_byte(cur_w[addr_i[2:0]], ptr_hi);
    else if (addr_i == OFS_STAT_CMD) rdata_o = status;
    else                            rdata_o = '0;
  end

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && rd_i && addr_i > 4'h8) |-> rdata_o == '0); // R13
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  tc = '0;
  logic [7:0]  cmd;
  logic [3:0]  mask, req;
  logic [23:0] mode;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tc_i(tc), .cmd_o(cmd), .mask_o(mask),
    .req_o(req), .mode_o(mode), .base_addr_o(base_addr), .cur_addr_o(cur_addr),
    .base_cnt_o(base_cnt), .cur_cnt_o(cur_cnt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read is on the bus
  initial forever begin
    @(negedge clk);
    #1;
    if (cs && rd && !wr && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {56'd0, rdata}, {56'd0, e});
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] e, input string t,
                        input logic [3:0] tcv = 4'h0);
    @(negedge clk); cs = 1; rd = 1; wr = 0; addr = a; tc = tcv;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); cs = 0; rd = 0; tc = '0;
  endtask

  task automatic tc_pulse(input logic [3:0] v);
    @(negedge clk); tc = v;
    @(negedge clk); tc = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", {60'd0, mask}, 64'hF);
    chk("R1 cmd", {56'd0, cmd}, 64'h0);
    chk("R1 req", {60'd0, req}, 64'h0);
    chk("R1 mode", {40'd0, mode}, 64'h0);
    rd_reg(4'h8, 8'h00, "R1 status");
    // R2 channel 1 address and count, low byte first
    wr_reg(4'h2, 8'h34); wr_reg(4'h2, 8'h12);
    chk("R2 base addr ch1", {48'd0, base_addr[31:16]}, 64'h1234);
    chk("R2 cur addr ch1", {48'd0, cur_addr[31:16]}, 64'h1234);
    wr_reg(4'h3, 8'hCD); wr_reg(4'h3, 8'hAB);
    chk("R2 base cnt ch1", {48'd0, base_cnt[31:16]}, 64'hABCD);
    chk("R2 cur cnt ch1", {48'd0, cur_cnt[31:16]}, 64'hABCD);
    // R3 reads toggle the shared pointer
    rd_reg(4'h2, 8'h34, "R3 read addr low");
    rd_reg(4'h2, 8'h12, "R3 read addr high");
    rd_reg(4'h3, 8'hCD, "R3 read cnt low");
    rd_reg(4'h3, 8'hAB, "R3 read cnt high");
    wr_reg(4'h2, 8'h78);
    rd_reg(4'h3, 8'hAB, "R3 pointer shared write->read");
    chk("R3 addr ch1 low replaced", {48'd0, cur_addr[31:16]}, 64'h1278);
    // R4 pointer clear ignores data
    wr_reg(4'h0, 8'h55);
    wr_reg(4'hC, 8'hFF);
    wr_reg(4'h0, 8'h66); wr_reg(4'h0, 8'h77);
    chk("R4 addr ch0 after clear", {48'd0, cur_addr[15:0]}, 64'h7766);
    // R9 mode fields
    wr_reg(4'hB, 8'hBA);
    chk("R9 mode ch2", {58'd0, mode[17:12]}, 64'h2E);
    wr_reg(4'hB, 8'h84);
    chk("R9 mode ch0", {58'd0, mode[5:0]}, 64'h21);
    chk("R9 mode ch1 untouched", {58'd0, mode[11:6]}, 64'h0);
    // R8 software requests honoured only in block mode
    wr_reg(4'h9, 8'h04);
    chk("R8 req ch0 block", {60'd0, req}, 64'h1);
    rd_reg(4'h8, 8'h10, "R8 status pending ch0");
    wr_reg(4'h9, 8'h05);
    chk("R8 req ch1 demand ignored", {60'd0, req}, 64'h1);
    wr_reg(4'h9, 8'h00);
    chk("R8 req ch0 cleared", {60'd0, req}, 64'h0);
    // R6 / R7 masks
    wr_reg(4'hE, 8'h00);
    chk("R6 clear all masks", {60'd0, mask}, 64'h0);
    wr_reg(4'hA, 8'h06);
    chk("R7 single mask ch2", {60'd0, mask}, 64'h4);
    wr_reg(4'hA, 8'h02);
    chk("R7 single unmask ch2", {60'd0, mask}, 64'h0);
    wr_reg(4'hF, 8'hFA);
    chk("R7 write all masks", {60'd0, mask}, 64'hA);
    // R12 command byte
    wr_reg(4'h8, 8'h41);
    chk("R12 cmd", {56'd0, cmd}, 64'h41);
    // R10 / R11 terminal count flags
    wr_reg(4'h9, 8'h04);
    tc_pulse(4'h5);
    rd_reg(4'h8, 8'h15, "R10 status tc and req");
    rd_reg(4'h8, 8'h10, "R11 tc cleared by read");
    rd_reg(4'h8, 8'h10, "R11 race read", 4'h8);
    rd_reg(4'h8, 8'h18, "R11 tc kept on race");
    rd_reg(4'h8, 8'h10, "R11 cleared after race");
    // R5 master reset
    wr_reg(4'h4, 8'h01);
    tc_pulse(4'h2);
    wr_reg(4'hD, 8'h00);
    chk("R5 mask set", {60'd0, mask}, 64'hF);
    chk("R5 cmd cleared", {56'd0, cmd}, 64'h0);
    chk("R5 req cleared", {60'd0, req}, 64'h0);
    chk("R5 mode kept", {58'd0, mode[17:12]}, 64'h2E);
    chk("R5 addr kept", {48'd0, cur_addr[31:16]}, 64'h1278);
    rd_reg(4'h8, 8'h00, "R5 status cleared");
    wr_reg(4'h4, 8'h22); wr_reg(4'h4, 8'h33);
    chk("R5 pointer cleared", {48'd0, cur_addr[47:32]}, 64'h3322);
    // R13 write-only offsets read zero; write wins over read
    rd_reg(4'hA, 8'h00, "R13 read A");
    rd_reg(4'hF, 8'h00, "R13 read F");
    @(negedge clk); cs = 1; wr = 1; rd = 1; addr = 4'h6; wdata = 8'h9C;
    @(negedge clk); cs = 0; wr = 0; rd = 0;
    wr_reg(4'h6, 8'h5A);
    chk("R13 write priority", {48'd0, cur_addr[63:48]}, 64'h5A9C);
    repeat (2) @(negedge clk);
    chk("scoreboard drained", {32'd0, 32'(exp_q.size())}, 64'h0);
    finish_run();
  end
endmodule